// File: doc/BRIEF.md
# Dual-Issue Pairing Check Unit

This block sits directly after instruction decode in an in-order processor with two execution pipes. The primary pipe has every resource. The secondary pipe handles only simple operations. Each cycle the block sees the two oldest decoded instructions: the older one (slot 1) and the younger one (slot 2). It decides whether both issue together, slot 1 to the primary pipe and slot 2 to the secondary pipe, or whether slot 1 issues alone. In the single-issue case the slot 2 instruction stays in the queue and becomes next cycle's slot 1 instruction.

The decision is registered. The two issue valids and a consumed count appear one clock after the inputs that produced them. The instruction queue advances by the consumed count.

Pairing needs all of the following:
- both instructions are simple;
- the younger one needs no primary-only resource;
- the older one is not a jump;
- no register dependence exists between them.

A condition-code write by the older instruction does not block a younger conditional jump. The two pair anyway, so a compare can issue together with the branch on its result.

Top module: `dual_issue_pair_check`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `uIssue`, `vIssue` and `consumed` are all 0.
- R2: Outputs are registered. When `i1Valid` is 1 and `stall` is 0 at a rising edge, `uIssue` is 1 after that edge.
- R3: `vIssue` is 0 unless both `i1Simple` and `i2Simple` are 1. A value of 1 means the instruction needs no microcode sequencing.
- R4: `vIssue` is 0 whenever `i2UOnly` is 1.
- R5: `vIssue` is 0 whenever `i1Jump` is 1.
- R6: `vIssue` is 0 when `i1Dst` equals any source field of `i2Srcs`. Source s occupies bits `[s*REG_W +: REG_W]`.
- R7: `vIssue` is 0 when `i1Dst` equals `i2Dst`.
- R8: With `ALLOW_CC_PAIR` = 1 (the default), `i1SetsCc` = 1 together with `i2CondJump` = 1 does not block pairing. When every other condition holds, both pipes issue.
- R9: `consumed` equals the number of issue valids set (0, 1 or 2). `vIssue` is never 1 while `uIssue` is 0.
- R10: When `stall` is 1 at an edge, both issue valids and `consumed` are 0 after that edge.
- R11: When `i2Valid` is 0, a valid unstalled slot 1 instruction still issues alone. When `i1Valid` is 0, nothing issues.
- R12: Register ID 0 has no special meaning. A slot 1 destination of 0 that matches a slot 2 source or destination of 0 blocks pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Downstream hold; suppresses all issue |
| i1Valid | input | 1 | Slot 1 holds an instruction |
| i1Simple | input | 1 | Slot 1 needs no microcode sequencing |
| i1Jump | input | 1 | Slot 1 is a jump of any kind |
| i1SetsCc | input | 1 | Slot 1 writes the condition codes |
| i1Dst | input | REG_W | Slot 1 destination register |
| i2Valid | input | 1 | Slot 2 holds an instruction |
| i2Simple | input | 1 | Slot 2 needs no microcode sequencing |
| i2UOnly | input | 1 | Slot 2 needs a primary-pipe-only resource |
| i2CondJump | input | 1 | Slot 2 is a conditional jump reading the condition codes |
| i2Dst | input | REG_W | Slot 2 destination register |
| i2Srcs | input | NUM_SRC*REG_W | Slot 2 source registers, packed |
| uIssue | output | 1 | Primary pipe receives slot 1 |
| vIssue | output | 1 | Secondary pipe receives slot 2 |
| consumed | output | 2 | Queue entries to retire this cycle |

## Verification
The assertions check on every cycle that each individual blocking condition forces single issue one cycle later:
- a stall;
- a non-simple instruction;
- a primary-only slot 2 instruction;
- a slot 1 jump;
- a read or write register conflict.

They also check that the count agrees with the valids. That a pair actually forms when nothing blocks it, and in particular that a condition-code producer pairs with a following conditional jump, is a liveness fact. Only the bench's sweep can show it. The sweep covers every flag combination against every register ID pattern of a 2-bit configuration.

// File: rtl/pair_pkg.sv
package pair_pkg;
  // Strobes from the pairing control into the datapath's issue register.
  typedef struct packed {
    logic issueU;
    logic issueV;
  } issue_strobe_t;
endpackage

// File: rtl/pair_hazard_dp.sv
module pair_hazard_dp
  import pair_pkg::*;
#(
  parameter int REG_W   = 3,
  parameter int NUM_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [REG_W-1:0]         i1Dst,
  input  logic [REG_W-1:0]         i2Dst,
  input  logic [NUM_SRC*REG_W-1:0] i2Srcs,
  input  issue_strobe_t            strobe,
  output logic                     rawHaz,
  output logic                     wawHaz,
  output logic                     uIssue,
  output logic                     vIssue,
  output logic [1:0]               consumed
);
  logic [NUM_SRC-1:0] srcHit;

  // One comparator per source operand of the younger instruction.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign srcHit[s] = (i2Srcs[s*REG_W +: REG_W] == i1Dst);
  end

  assign rawHaz = |srcHit;
  assign wawHaz = (i1Dst == i2Dst);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uIssue   <= 1'b0;
      vIssue   <= 1'b0;
      consumed <= 2'd0;
    end else begin
      uIssue   <= strobe.issueU;
      vIssue   <= strobe.issueV;
      consumed <= {1'b0, strobe.issueU} + {1'b0, strobe.issueV};
    end
  end
endmodule

// File: rtl/pair_ctrl.sv
module pair_ctrl
  import pair_pkg::*;
#(
  parameter bit ALLOW_CC_PAIR = 1'b1
) (
  input  logic          stall,
  input  logic          i1Valid,
  input  logic          i1Simple,
  input  logic          i1Jump,
  input  logic          i1SetsCc,
  input  logic          i2Valid,
  input  logic          i2Simple,
  input  logic          i2UOnly,
  input  logic          i2CondJump,
  input  logic          rawHaz,
  input  logic          wawHaz,
  output issue_strobe_t strobe
);
  logic ccDep;
  logic ccBlock;
  logic bothSimple;
  logic pairOk;

  assign ccDep      = i1SetsCc & i2CondJump;
  assign ccBlock    = ccDep & ~ALLOW_CC_PAIR;
  assign bothSimple = i1Simple & i2Simple;

  always_comb begin
    pairOk = i1Valid & i2Valid & bothSimple;
    if (i2UOnly || i1Jump)  pairOk = 1'b0;
    if (rawHaz || wawHaz)   pairOk = 1'b0;
    if (ccBlock)            pairOk = 1'b0;
    strobe.issueU = i1Valid & ~stall;
    strobe.issueV = pairOk & ~stall;
  end
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import pair_pkg::*;
#(
  parameter int REG_W         = 3,
  parameter int NUM_SRC       = 2,
  parameter bit ALLOW_CC_PAIR = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stall,
  input  logic                     i1Valid,
  input  logic                     i1Simple,
  input  logic                     i1Jump,
  input  logic                     i1SetsCc,
  input  logic [REG_W-1:0]         i1Dst,
  input  logic                     i2Valid,
  input  logic                     i2Simple,
  input  logic                     i2UOnly,
  input  logic                     i2CondJump,
  input  logic [REG_W-1:0]         i2Dst,
  input  logic [NUM_SRC*REG_W-1:0] i2Srcs,
  output logic                     uIssue,
  output logic                     vIssue,
  output logic [1:0]               consumed
);
  issue_strobe_t strobe;
  logic          rawHaz;
  logic          wawHaz;

  pair_ctrl #(.ALLOW_CC_PAIR(ALLOW_CC_PAIR)) u_ctrl (
    .stall(stall), .i1Valid(i1Valid), .i1Simple(i1Simple), .i1Jump(i1Jump),
    .i1SetsCc(i1SetsCc), .i2Valid(i2Valid), .i2Simple(i2Simple),
    .i2UOnly(i2UOnly), .i2CondJump(i2CondJump), .rawHaz(rawHaz),
    .wawHaz(wawHaz), .strobe(strobe)
  );

  pair_hazard_dp #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .i1Dst(i1Dst), .i2Dst(i2Dst), .i2Srcs(i2Srcs),
    .strobe(strobe), .rawHaz(rawHaz), .wawHaz(wawHaz),
    .uIssue(uIssue), .vIssue(vIssue), .consumed(consumed)
  );
endmodule

// File: rtl/dual_issue_pair_check_sva.sv
module dual_issue_pair_check_sva #(
  parameter int REG_W   = 3,
  parameter int NUM_SRC = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     stall,
  input logic                     i1Valid,
  input logic                     i1Simple,
  input logic                     i1Jump,
  input logic [REG_W-1:0]         i1Dst,
  input logic                     i2Simple,
  input logic                     i2UOnly,
  input logic [REG_W-1:0]         i2Dst,
  input logic [NUM_SRC*REG_W-1:0] i2Srcs,
  input logic                     uIssue,
  input logic                     vIssue,
  input logic [1:0]               consumed
);
  logic srcMatch;
  always_comb begin
    srcMatch = 1'b0;
    for (int s = 0; s < NUM_SRC; s++)
      if (i2Srcs[s*REG_W +: REG_W] == i1Dst) srcMatch = 1'b1;
  end

  a_r2_single_issue: assert property (@(posedge clk) disable iff (!rstN)
    (i1Valid && !stall) |=> uIssue);
  a_r3_needs_simple: assert property (@(posedge clk) disable iff (!rstN)
    !(i1Simple && i2Simple) |=> !vIssue);
  a_r4_uonly_blocks: assert property (@(posedge clk) disable iff (!rstN)
    i2UOnly |=> !vIssue);
  a_r5_jump_blocks: assert property (@(posedge clk) disable iff (!rstN)
    i1Jump |=> !vIssue);
  a_r6_raw_blocks: assert property (@(posedge clk) disable iff (!rstN)
    srcMatch |=> !vIssue);
  a_r7_waw_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (i1Dst == i2Dst) |=> !vIssue);
  a_r9_count_matches: assert property (@(posedge clk) disable iff (!rstN)
    (consumed == 2'(uIssue) + 2'(vIssue)) && !(vIssue && !uIssue));
  a_r10_stall_idle: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (!uIssue && !vIssue && consumed == 2'd0));
  a_r11_no_slot1: assert property (@(posedge clk) disable iff (!rstN)
    !i1Valid |=> (!uIssue && !vIssue));
endmodule

bind dual_issue_pair_check dual_issue_pair_check_sva #(
  .REG_W(REG_W), .NUM_SRC(NUM_SRC)
) u_sva (
  .clk(clk), .rstN(rstN), .stall(stall), .i1Valid(i1Valid),
  .i1Simple(i1Simple), .i1Jump(i1Jump), .i1Dst(i1Dst),
  .i2Simple(i2Simple), .i2UOnly(i2UOnly), .i2Dst(i2Dst), .i2Srcs(i2Srcs),
  .uIssue(uIssue), .vIssue(vIssue), .consumed(consumed)
);

// File: tb/dual_issue_pair_check_bench.sv
`timescale 1ns/1ps
module dual_issue_pair_check_bench;
  localparam int RW = 2;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stall = 1'b1;
  logic i1Valid = 0, i1Simple = 0, i1Jump = 0, i1SetsCc = 0;
  logic i2Valid = 0, i2Simple = 0, i2UOnly = 0, i2CondJump = 0;
  logic [RW-1:0] i1Dst = '0, i2Dst = '0;
  logic [NS*RW-1:0] i2Srcs = '0;
  logic uIssue, vIssue;
  logic [1:0] consumed;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  dual_issue_pair_check #(.REG_W(RW), .NUM_SRC(NS), .ALLOW_CC_PAIR(1'b1)) u_dual_issue_pair_check (
    .clk(clk), .rstN(rstN), .stall(stall), .i1Valid(i1Valid), .i1Simple(i1Simple),
    .i1Jump(i1Jump), .i1SetsCc(i1SetsCc), .i1Dst(i1Dst), .i2Valid(i2Valid),
    .i2Simple(i2Simple), .i2UOnly(i2UOnly), .i2CondJump(i2CondJump),
    .i2Dst(i2Dst), .i2Srcs(i2Srcs), .uIssue(uIssue), .vIssue(vIssue),
    .consumed(consumed)
  );

  task automatic check(input string tag, input logic eU, input logic eV, input logic [1:0] eC);
    nChecks++;
    if (uIssue !== eU || vIssue !== eV || consumed !== eC) begin
      nFail++;
      $display("FAIL %s actual u=%0b v=%0b n=%0d expected u=%0b v=%0b n=%0d",
               tag, uIssue, vIssue, consumed, eU, eV, eC);
    end
  endtask

  logic expU, expV;
  logic [1:0] expC;
  string expTag;
  logic havePrev;

  initial begin
    havePrev = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0, 2'd0);           // R1: held in reset
    rstN = 1'b1;                               // stall still high
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 2'd0);           // R1: first cycle after release
    for (int vec = 0; vec < (1 << 17); vec++) begin
      logic raw, waw, ok;
      if (havePrev) check(expTag, expU, expV, expC);
      stall      = vec[0];
      i1Valid    = vec[1];
      i1Simple   = vec[2];
      i1Jump     = vec[3];
      i1SetsCc   = vec[4];
      i2Valid    = vec[5];
      i2Simple   = vec[6];
      i2UOnly    = vec[7];
      i2CondJump = vec[8];
      i1Dst      = vec[10:9];
      i2Dst      = vec[12:11];
      i2Srcs     = vec[16:13];
      raw = (i2Srcs[1:0] == i1Dst) || (i2Srcs[3:2] == i1Dst);
      waw = (i2Dst == i1Dst);
      ok  = !stall && i1Valid && i2Valid && i1Simple && i2Simple &&
            !i2UOnly && !i1Jump && !raw && !waw;
      expU = !stall && i1Valid;
      expV = ok;
      expC = 2'(expU) + 2'(expV);
      if (stall)                       expTag = "R10";
      else if (!i1Valid || !i2Valid)   expTag = "R11";
      else if (!i1Simple || !i2Simple) expTag = "R3";
      else if (i2UOnly)                expTag = "R4";
      else if (i1Jump)                 expTag = "R5";
      else if ((raw || waw) && i1Dst == 0) expTag = "R12";
      else if (raw)                    expTag = "R6";
      else if (waw)                    expTag = "R7";
      else if (i1SetsCc && i2CondJump) expTag = "R8";
      else                             expTag = "R9";
      havePrev = 1'b1;
      @(negedge clk);
    end
    check(expTag, expU, expV, expC);

    // R2: one-cycle latency of a lone issue, then R12 with register zero.
    stall = 0; i1Valid = 1; i1Simple = 1; i1Jump = 0; i1SetsCc = 0;
    i2Valid = 0; i2Simple = 1; i2UOnly = 0; i2CondJump = 0;
    i1Dst = 2'd0; i2Dst = 2'd3; i2Srcs = {2'd1, 2'd0};
    @(negedge clk);
    check("R2", 1'b1, 1'b0, 2'd1);
    i2Valid = 1;                               // source 0 matches dest 0
    @(negedge clk);
    check("R12", 1'b1, 1'b0, 2'd1);
    i2Srcs = {2'd1, 2'd2};                     // independent, CC pair
    i1SetsCc = 1; i2CondJump = 1;
    @(negedge clk);
    check("R8", 1'b1, 1'b1, 2'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule